// File: doc/BRIEF.md
# Multi-Line Write Burst Checker

This block watches the request side of a memory-write channel. On every clock it sees a valid strobe, a start-of-packet mark, a burst-length code, the low cache-line address bits and a request kind. It enforces the rules for writes that span one, two or four cache lines. A burst must open with a start-of-packet beat at its lowest address, and that address must be naturally aligned to the burst size. The beats that follow carry low address bits that step up by one. The burst has exactly as many beats as its length says, and nothing else may be issued until its last beat has gone out.

Idle cycles (valid low) between beats are legal. The checker keeps one sticky flag per rule, and a synchronous clear input resets the flags. A single-cycle completion pulse marks the end of each burst. Only the two low cache-line address bits reach the checker. The higher address bits are don't-care on continuation beats and play no part in any rule, so they are not brought in.

Top module: `wrb_checker`

## Requirements
- R1: Length codes are 0 = one line, 1 = two lines, 3 = four lines. A start-of-packet write carrying code 2 sets error bit 0 and opens no burst.
- R2: A start-of-packet write with a legal length whose low address is not a multiple of the line count sets error bit 1. The burst still opens.
- R3: A write with start-of-packet low while no burst is open sets error bit 2.
- R4: Each continuation write must carry low address bits equal to the previous beat's plus one, modulo 4. Otherwise error bit 3 is set. The expected value still advances.
- R5: A start-of-packet write while a burst is open sets error bit 4. The old burst is abandoned and the new header starts a fresh burst.
- R6: A continuation write whose length code differs from the code latched at start-of-packet sets error bit 5.
- R7: A request of kind fence (1), interrupt (2) or byte-enable write (3) while a burst is open sets error bit 6. It does not count as a beat. The same kinds with no burst open raise no error. Kind 0 is a plain write.
- R8: An N-line burst closes on its Nth valid write beat. Idle cycles between beats neither count as beats nor change the state.
- R9: `burst_done` is high for exactly the one cycle after the closing beat. For a one-line burst, that beat is its start-of-packet beat.
- R10: Error flags stay set until `err_clr` is sampled high. A new error in the same cycle as the clear stays set. After reset, all flags and `burst_done` are low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_clr | input | 1 | Synchronous clear of all error flags |
| req_valid | input | 1 | Request present this cycle |
| req_sop | input | 1 | First beat of a burst |
| req_len | input | 2 | Burst-length code |
| req_addr_lo | input | 2 | Low cache-line address bits |
| req_kind | input | 2 | Request kind: write, fence, interrupt, byte-enable write |
| err_flags | output | 7 | Sticky error flags, one bit per rule |
| burst_done | output | 1 | One-cycle pulse after a burst closes |

## Verification
The assertions assume that every input is a known value on each clock edge and that `req_len`, `req_addr_lo` and `req_kind` only matter when `req_valid` is high. The stimulus therefore drives every field on a falling edge, holds it steady through the next rising edge, and parks the fields at zero when valid is low. Beyond that, the assertions make no assumption that the traffic is legal. The stimulus deliberately breaks each rule in turn, and before every break it clears the flags so that each error shows up on its own.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
    localparam int LEN_W   = 2;
    localparam int LO_W    = 2;
    localparam int KIND_W  = 2;

    typedef enum logic [LEN_W-1:0] {
        LEN_ONE  = 2'd0,
        LEN_TWO  = 2'd1,
        LEN_RSVD = 2'd2,
        LEN_FOUR = 2'd3
    } len_code_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_WR    = 2'd0,
        KIND_FENCE = 2'd1,
        KIND_INTR  = 2'd2,
        KIND_BEWR  = 2'd3
    } kind_e;

    localparam int E_LEN   = 0;
    localparam int E_ALIGN = 1;
    localparam int E_NOSOP = 2;
    localparam int E_INCR  = 3;
    localparam int E_ILV   = 4;
    localparam int E_MISM  = 5;
    localparam int E_INTR  = 6;
    localparam int ERR_N   = 7;

    typedef struct packed {
        logic            open;
        logic [LO_W-1:0] remain;
        logic [LO_W-1:0] exp_lo;
        logic [LEN_W-1:0] len;
        logic            done;
    } trk_t;
endpackage

// File: rtl/wrb_beat_decode.sv
module wrb_beat_decode
    import wrb_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int AW = LO_W
) (
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] addr_lo,
    output logic          len_legal,
    output logic [AW-1:0] span,
    output logic          align_ok
);
    always_comb begin
        len_legal = 1'b1;
        span      = '0;
        case (len)
            LEN_ONE:  span = AW'(0);
            LEN_TWO:  span = AW'(1);
            LEN_FOUR: span = AW'(3);
            default:  len_legal = 1'b0;
        endcase
        // span is N-1 with N a power of two, so alignment is a mask test
        align_ok = ((addr_lo & span) == '0);
    end
endmodule

// File: rtl/wrb_sticky_flags.sv
module wrb_sticky_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flag_q
);
    logic [N-1:0] flag_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            flag_d[i] = set[i] | (flag_q[i] & ~clr);
        end
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flag_d[i];
        end

        a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] && !clr |=> flag_q[i]);
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag_q[i]);
        a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr && !set[i] |=> !flag_q[i]);
    end
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker
    import wrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_clr,
    input  logic              req_valid,
    input  logic              req_sop,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LO_W-1:0]   req_addr_lo,
    input  logic [KIND_W-1:0] req_kind,
    output logic [ERR_N-1:0]  err_flags,
    output logic              burst_done
);
    trk_t             trk_d, trk_q;
    logic [ERR_N-1:0] err_set;
    logic             len_legal, align_ok;
    logic [LO_W-1:0]  span;
    logic             is_wr, is_other;

    wrb_beat_decode #(.LW(LEN_W), .AW(LO_W)) u_dec (
        .len       (req_len),
        .addr_lo   (req_addr_lo),
        .len_legal (len_legal),
        .span      (span),
        .align_ok  (align_ok)
    );

    always_comb begin
        trk_d      = trk_q;
        trk_d.done = 1'b0;
        err_set    = '0;
        is_wr      = req_valid && (req_kind == KIND_WR);
        is_other   = req_valid && (req_kind != KIND_WR);

        if (is_other && trk_q.open) err_set[E_INTR] = 1'b1;

        if (is_wr && req_sop) begin
            if (trk_q.open) err_set[E_ILV] = 1'b1;
            if (!len_legal) begin
                err_set[E_LEN] = 1'b1;
                trk_d.open     = 1'b0;
            end else begin
                if (!align_ok) err_set[E_ALIGN] = 1'b1;
                if (span == '0) begin
                    trk_d.open = 1'b0;
                    trk_d.done = 1'b1;
                end else begin
                    trk_d.open   = 1'b1;
                    trk_d.remain = span;
                    trk_d.exp_lo = req_addr_lo + LO_W'(1);
                    trk_d.len    = req_len;
                end
            end
        end else if (is_wr) begin
            if (!trk_q.open) begin
                err_set[E_NOSOP] = 1'b1;
            end else begin
                if (req_len != trk_q.len)        err_set[E_MISM] = 1'b1;
                if (req_addr_lo != trk_q.exp_lo) err_set[E_INCR] = 1'b1;
                trk_d.exp_lo = trk_q.exp_lo + LO_W'(1);
                trk_d.remain = trk_q.remain - LO_W'(1);
                if (trk_q.remain == LO_W'(1)) begin
                    trk_d.open = 1'b0;
                    trk_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    wrb_sticky_flags #(.N(ERR_N)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (err_clr),
        .set    (err_set),
        .flag_q (err_flags)
    );

    assign burst_done = trk_q.done;

    // R9: a completion pulse needs a write beat on the previous cycle
    a_r9_done_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_kind == KIND_WR) |=> !burst_done);
    // R8: idle cycles leave the burst state untouched
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(trk_q.open) && $stable(trk_q.remain) && $stable(trk_q.exp_lo));
    // R7: other request kinds inside a burst are flagged
    a_r7_intrude: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind != KIND_WR && trk_q.open |=> err_flags[E_INTR]);
    // R3: continuation beat with nothing open is flagged
    a_r3_missing_sop: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_kind == KIND_WR && !req_sop && !trk_q.open |=> err_flags[E_NOSOP]);
    // R8: an open burst always has beats left to send
    a_r8_open_has_beats: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.open |-> trk_q.remain != '0);
endmodule

// File: tb/wrb_checker_tb.sv
module wrb_checker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_clr = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_sop = 1'b0;
    logic [1:0] req_len = '0;
    logic [1:0] req_addr_lo = '0;
    logic [1:0] req_kind = '0;
    logic [6:0] err_flags;
    logic       burst_done;
    int         checks = 0;
    int         errors = 0;
    bit         ended = 1'b0;

    always #10 clk = ~clk;

    wrb_checker dut_i (
        .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .req_valid(req_valid),
        .req_sop(req_sop), .req_len(req_len), .req_addr_lo(req_addr_lo),
        .req_kind(req_kind), .err_flags(err_flags), .burst_done(burst_done)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(bit v, bit sop, int len, int lo, int kind, bit clr);
        @(negedge clk);
        req_valid   = v;
        req_sop     = sop;
        req_len     = 2'(len);
        req_addr_lo = 2'(lo);
        req_kind    = 2'(kind);
        err_clr     = clr;
        @(posedge clk);
        #1;
        @(negedge clk);
        req_valid = 1'b0; req_sop = 1'b0; req_len = '0;
        req_addr_lo = '0; req_kind = '0; err_clr = 1'b0;
    endtask

    task automatic beat(bit sop, int len, int lo);
        cyc(1'b1, sop, len, lo, 0, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 0, 0, 0, 1'b0);
    endtask

    task automatic clear();
        cyc(1'b0, 1'b0, 0, 0, 0, 1'b1);
    endtask

    // cyc returns at the falling edge after the sampling edge; outputs there
    // reflect the driven beat, since no further rising edge has occurred.

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 reset flags", int'(err_flags), 0);
        check("R10 reset done", int'(burst_done), 0);
        beat(1'b0, 3, 1);
        check("R10 R3 idle after reset", int'(err_flags), 1 << 2);

        // Sweep every length code and every start address
        for (int code = 0; code < 4; code++) begin
            for (int a = 0; a < 4; a++) begin
                int n;
                int exp_e;
                n = (code == 0) ? 1 : (code == 1) ? 2 : 4;
                clear();
                check("R10 clear", int'(err_flags), 0);
                if (code == 2) begin
                    beat(1'b1, code, a);
                    check("R1 reserved length", int'(err_flags), 1 << 0);
                    check("R1 no done", int'(burst_done), 0);
                    beat(1'b0, code, a + 1);
                    check("R1 no burst opened", int'(err_flags), (1 << 0) | (1 << 2));
                end else begin
                    exp_e = ((a % n) != 0) ? (1 << 1) : 0;
                    for (int k = 0; k < n; k++) begin
                        beat(k == 0, code, (a + k) % 4);
                        check("R2 R4 sweep flags", int'(err_flags), exp_e);
                        check("R8 R9 sweep done", int'(burst_done), (k == n - 1) ? 1 : 0);
                        if (k % 2 == 1) begin
                            idle();
                            check("R9 done one cycle", int'(burst_done), 0);
                        end
                    end
                end
            end
        end

        // Length mismatch on a continuation beat
        clear();
        beat(1'b1, 3, 0);
        beat(1'b0, 1, 1);
        check("R6 mismatch", int'(err_flags), 1 << 5);
        beat(1'b0, 3, 2);
        beat(1'b0, 3, 3);
        check("R8 four beats close", int'(burst_done), 1);

        // Bad increment
        clear();
        beat(1'b1, 1, 2);
        beat(1'b0, 1, 2);
        check("R4 bad increment", int'(err_flags), 1 << 3);
        check("R4 still closes", int'(burst_done), 1);

        // Interleaved start-of-packet
        clear();
        beat(1'b1, 3, 0);
        beat(1'b0, 3, 1);
        beat(1'b1, 0, 2);
        check("R5 interleave", int'(err_flags), 1 << 4);
        check("R5 new burst completes", int'(burst_done), 1);
        beat(1'b0, 3, 2);
        check("R5 old burst abandoned", int'(err_flags), (1 << 4) | (1 << 2));

        // Other kinds inside and outside a burst
        for (int kd = 1; kd < 4; kd++) begin
            clear();
            cyc(1'b1, 1'b0, 0, 0, kd, 1'b0);
            check("R7 kind outside burst", int'(err_flags), 0);
            beat(1'b1, 1, 0);
            cyc(1'b1, 1'b0, 0, 0, kd, 1'b0);
            check("R7 kind inside burst", int'(err_flags), 1 << 6);
            check("R7 not a beat", int'(burst_done), 0);
            beat(1'b0, 1, 1);
            check("R7 burst still closes", int'(burst_done), 1);
        end

        // Clear in the same cycle as a new error
        beat(1'b0, 0, 0);
        cyc(1'b1, 1'b0, 0, 0, 0, 1'b1);
        check("R10 set wins over clear", int'(err_flags), 1 << 2);
        idle();
        check("R10 flags sticky", int'(err_flags), 1 << 2);

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule